// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the input divider N and the feedback multiplier M for a PLL whose VCO has to land as close as possible to a wanted lane rate. A single start pulse samples the reference frequency, the pixel clock, the bits per pixel and the lane count. The block first derives the wanted lane rate from the pixel clock. It then walks N over the span allowed by the reference-over-N limits. For each N it forms M, makes M even, computes the resulting VCO frequency and keeps the closest legal candidate.

All arithmetic runs through one shared iterative restoring divider, which handles one or more quotient bits per clock. Frequencies are in kHz and rates are in Mbit/s. The results stay on the outputs until the next accepted start. A one-cycle done pulse marks them valid.

Top module: `pll_div_search`

## Requirements
- R1: N runs from ceil(fin_khz / 40000) to floor(fin_khz / 5000). A lower bound of 0 is raised to 1. When the lower bound exceeds the upper one, no candidate is tried and done arrives with found = 0.
- R2: target = floor(floor(pclk_khz × floor(bpp / lanes) × 10 / 8) / 1000) Mbit/s. If pclk_khz is 0, or the target is 1500 or more, the target becomes 1000. The wanted VCO frequency is target × 1000 kHz.
- R3: For each N, M = floor(fout × N / fin_khz). A candidate with M below 6 or above 512 is skipped. Otherwise an odd M is raised by one, so best_m is always even and lies in 6..512.
- R4: The achieved frequency is floor(M × fin_khz / N) kHz. A candidate whose frequency is outside 80000..1500000 kHz is rejected.
- R5: The error is |fout − achieved|. A candidate replaces the stored best only when its error is strictly smaller. On a tie, the smaller N is kept.
- R6: When a candidate is found, found = 1 and lane_mbps = ceil(best_freq_khz / 1000). When none is found, found = 0 and best_n, best_m, best_freq_khz and lane_mbps are all 0.
- R7: Inputs are sampled only by a start pulse while the block is idle. A start pulse while busy is ignored and does not change the result.
- R8: busy is 1 from the cycle after an accepted start until done. done is a one-cycle pulse with busy = 0. The outputs hold their values until the next accepted start.
- R9: After reset, busy, done and found are 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| fin_khz | input | FIN_W | PLL reference frequency in kHz |
| pclk_khz | input | PCLK_W | Pixel clock in kHz |
| bpp | input | BPP_W | Bits per pixel |
| lanes | input | LANE_W | Data lane count (non-zero) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| found | output | 1 | A legal candidate was found |
| best_n | output | FIN_W | Chosen input divider |
| best_m | output | clog2(M_MAX+1) | Chosen even feedback multiplier |
| best_freq_khz | output | DW | Achieved VCO frequency in kHz |
| lane_mbps | output | clog2(VCO_MAX_KHZ/1000+2) | Achieved lane rate rounded up, Mbit/s |

## Verification
Two events can fall in the same cycle: a candidate improving the stored best, and the loop reaching the last N. In that cycle the rounding division for the lane rate must be launched from the freshly updated frequency rather than the stale one. This is provoked by random reference frequencies and pixel clocks, and by a wide 1 GHz reference, where the best candidate often sits at the top of the N range. It is judged by comparing best_n, best_freq_khz and lane_mbps with a bench model that walks the same search. A second collision, a start pulse arriving mid-search, is driven with different inputs and judged by the result still matching the first start.

// File: rtl/psrch_pkg.sv
package psrch_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_QUOT,
      ST_RATE,
      ST_NMIN,
      ST_NMAX,
      ST_MDIV,
      ST_FDIV,
      ST_LANE
   } srch_state_e;
endpackage

// File: rtl/psrch_divider.sv
module psrch_divider #(
   parameter int DW    = 32,
   parameter int STEPS = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] num,
   input  logic [DW-1:0] den,
   output logic [DW-1:0] quo,
   output logic [DW-1:0] rem,
   output logic          done
);
   localparam int ITER = DW / STEPS;
   localparam int CW   = $clog2(ITER + 1);

   if (STEPS < 1 || (DW % STEPS) != 0) begin : g_bad_steps
      $error("psrch_divider: STEPS must divide DW");
   end

   logic [DW-1:0] rem_q, quo_q, den_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, done_q;

   logic [DW-1:0] r_s [0:STEPS];
   logic [DW-1:0] q_s [0:STEPS];

   assign r_s[0] = rem_q;
   assign q_s[0] = quo_q;

   for (genvar i = 0; i < STEPS; i++) begin : g_stage
      logic [DW:0] trial;
      logic        ge;
      assign trial      = {r_s[i], q_s[i][DW-1]};
      assign ge         = trial >= {1'b0, den_q};
      assign r_s[i+1]   = ge ? DW'(trial - {1'b0, den_q}) : trial[DW-1:0];
      assign q_s[i+1]   = {q_s[i][DW-2:0], ge};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= CW'(ITER);
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= r_s[STEPS];
            quo_q <= q_s[STEPS];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign quo  = quo_q;
   assign rem  = rem_q;
   assign done = done_q;
endmodule

// File: rtl/psrch_cand.sv
module psrch_cand #(
   parameter int DW          = 32,
   parameter int MW          = 10,
   parameter int M_MIN       = 6,
   parameter int M_MAX       = 512,
   parameter int VCO_MIN_KHZ = 80000,
   parameter int VCO_MAX_KHZ = 1500000
) (
   input  logic [DW-1:0] quo,
   input  logic [DW-1:0] fout,
   input  logic [DW-1:0] best_err,
   output logic          m_ok,
   output logic [MW-1:0] m_even,
   output logic          f_ok,
   output logic [DW-1:0] err,
   output logic          better
);
   always_comb begin
      m_ok   = (quo >= DW'(M_MIN)) && (quo <= DW'(M_MAX));
      m_even = MW'(quo) + MW'(quo[0]);
      f_ok   = (quo >= DW'(VCO_MIN_KHZ)) && (quo <= DW'(VCO_MAX_KHZ));
      err    = (fout >= quo) ? (fout - quo) : (quo - fout);
      better = err < best_err;
   end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
   import psrch_pkg::*;
#(
   parameter int FIN_W       = 20,
   parameter int PCLK_W      = 20,
   parameter int BPP_W       = 6,
   parameter int LANE_W      = 3,
   parameter int DW          = 32,
   parameter int STEPS       = 1,
   parameter int REF_MIN_KHZ = 5000,
   parameter int REF_MAX_KHZ = 40000,
   parameter int VCO_MIN_KHZ = 80000,
   parameter int VCO_MAX_KHZ = 1500000,
   parameter int M_MIN       = 6,
   parameter int M_MAX       = 512,
   parameter int RATE_CAP    = 1500,
   parameter int RATE_DFLT   = 1000
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   input  logic [FIN_W-1:0]                      fin_khz,
   input  logic [PCLK_W-1:0]                     pclk_khz,
   input  logic [BPP_W-1:0]                      bpp,
   input  logic [LANE_W-1:0]                     lanes,
   output logic                                  busy,
   output logic                                  done,
   output logic                                  found,
   output logic [FIN_W-1:0]                      best_n,
   output logic [$clog2(M_MAX+1)-1:0]            best_m,
   output logic [DW-1:0]                         best_freq_khz,
   output logic [$clog2(VCO_MAX_KHZ/1000+2)-1:0] lane_mbps
);
   localparam int NW = FIN_W;
   localparam int MW = $clog2(M_MAX + 1);
   localparam int RW = $clog2(VCO_MAX_KHZ / 1000 + 2);
   localparam int PW = PCLK_W + BPP_W;

   if (DW < FIN_W + MW + 1 || DW < PW + 1) begin : g_bad_width
      $error("pll_div_search: DW too narrow for the products");
   end

   srch_state_e   st_q;
   logic [DW-1:0] div_num_q, div_den_q, div_quo, div_rem;
   logic          div_go_q, div_done;
   logic [DW-1:0] fin_q, fout_q, err_best_q, best_f_q;
   logic [PCLK_W-1:0] pclk_q;
   logic [NW-1:0] n_q, nmax_q, best_n_q, n_inc;
   logic [MW-1:0] m_q, best_m_q, m_even;
   logic [RW-1:0] lane_q;
   logic          found_q, done_q;
   logic          m_ok, f_ok, better, fdiv_upd, step_n, last_n, found_nx;
   logic [DW-1:0] cand_err, freq_nx, tgt_rate;
   logic [PW-1:0] rate_prod;
   logic [PW+3:0] rate_scaled;

   psrch_divider #(.DW(DW), .STEPS(STEPS)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (div_go_q),
      .num  (div_num_q),
      .den  (div_den_q),
      .quo  (div_quo),
      .rem  (div_rem),
      .done (div_done)
   );

   psrch_cand #(
      .DW(DW), .MW(MW), .M_MIN(M_MIN), .M_MAX(M_MAX),
      .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ)
   ) u_cand (
      .quo     (div_quo),
      .fout    (fout_q),
      .best_err(err_best_q),
      .m_ok    (m_ok),
      .m_even  (m_even),
      .f_ok    (f_ok),
      .err     (cand_err),
      .better  (better)
   );

   always_comb begin
      rate_prod   = PW'(pclk_q) * PW'(div_quo[BPP_W-1:0]);
      rate_scaled = ({4'b0000, rate_prod} * (PW+4)'(10)) >> 3;
      tgt_rate    = (pclk_q != '0 && div_quo < DW'(RATE_CAP)) ? div_quo : DW'(RATE_DFLT);
      fdiv_upd    = (st_q == ST_FDIV) && div_done && f_ok && better;
      step_n      = div_done && (((st_q == ST_MDIV) && !m_ok) || (st_q == ST_FDIV));
      last_n      = (n_q == nmax_q);
      n_inc       = n_q + 1'b1;
      found_nx    = found_q | fdiv_upd;
      freq_nx     = fdiv_upd ? div_quo : best_f_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         div_num_q  <= '0;
         div_den_q  <= '0;
         div_go_q   <= 1'b0;
         fin_q      <= '0;
         fout_q     <= '0;
         pclk_q     <= '0;
         err_best_q <= '1;
         n_q        <= '0;
         nmax_q     <= '0;
         m_q        <= '0;
         best_n_q   <= '0;
         best_m_q   <= '0;
         best_f_q   <= '0;
         lane_q     <= '0;
         found_q    <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         div_go_q <= 1'b0;
         done_q   <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               fin_q      <= DW'(fin_khz);
               pclk_q     <= pclk_khz;
               err_best_q <= '1;
               found_q    <= 1'b0;
               best_n_q   <= '0;
               best_m_q   <= '0;
               best_f_q   <= '0;
               lane_q     <= '0;
               div_num_q  <= DW'(bpp);
               div_den_q  <= DW'(lanes);
               div_go_q   <= 1'b1;
               st_q       <= ST_QUOT;
            end
            ST_QUOT: if (div_done) begin
               div_num_q <= DW'(rate_scaled);
               div_den_q <= DW'(1000);
               div_go_q  <= 1'b1;
               st_q      <= ST_RATE;
            end
            ST_RATE: if (div_done) begin
               fout_q    <= tgt_rate * DW'(1000);
               div_num_q <= fin_q + DW'(REF_MAX_KHZ - 1);
               div_den_q <= DW'(REF_MAX_KHZ);
               div_go_q  <= 1'b1;
               st_q      <= ST_NMIN;
            end
            ST_NMIN: if (div_done) begin
               n_q       <= (div_quo == '0) ? NW'(1) : NW'(div_quo);
               div_num_q <= fin_q;
               div_den_q <= DW'(REF_MIN_KHZ);
               div_go_q  <= 1'b1;
               st_q      <= ST_NMAX;
            end
            ST_NMAX: if (div_done) begin
               nmax_q <= NW'(div_quo);
               if (DW'(n_q) > div_quo) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  div_num_q <= fout_q * DW'(n_q);
                  div_den_q <= fin_q;
                  div_go_q  <= 1'b1;
                  st_q      <= ST_MDIV;
               end
            end
            ST_MDIV: if (div_done && m_ok) begin
               m_q       <= m_even;
               div_num_q <= DW'(m_even) * fin_q;
               div_den_q <= DW'(n_q);
               div_go_q  <= 1'b1;
               st_q      <= ST_FDIV;
            end
            ST_FDIV: if (fdiv_upd) begin
               best_n_q   <= n_q;
               best_m_q   <= m_q;
               best_f_q   <= div_quo;
               err_best_q <= cand_err;
               found_q    <= 1'b1;
            end
            ST_LANE: if (div_done) begin
               lane_q <= RW'(div_quo);
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
         if (step_n) begin
            if (last_n) begin
               if (found_nx) begin
                  div_num_q <= freq_nx + DW'(999);
                  div_den_q <= DW'(1000);
                  div_go_q  <= 1'b1;
                  st_q      <= ST_LANE;
               end else begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end else begin
               n_q       <= n_inc;
               div_num_q <= fout_q * DW'(n_inc);
               div_den_q <= fin_q;
               div_go_q  <= 1'b1;
               st_q      <= ST_MDIV;
            end
         end
      end
   end

   assign busy          = (st_q != ST_IDLE);
   assign done          = done_q;
   assign found         = found_q;
   assign best_n        = best_n_q;
   assign best_m        = best_m_q;
   assign best_freq_khz = best_f_q;
   assign lane_mbps     = lane_q;

   // R3 (every floor division the search relies on)
   div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_done && div_den_q != '0) |->
         (64'(div_quo) * 64'(div_den_q) + 64'(div_rem) == 64'(div_num_q)) && (div_rem < div_den_q));

   // R3
   m_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (best_m >= MW'(M_MIN)) && (best_m <= MW'(M_MAX)) && !best_m[0]);

   // R4
   vco_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (best_freq_khz >= DW'(VCO_MIN_KHZ)) && (best_freq_khz <= DW'(VCO_MAX_KHZ)));

   // R1
   n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (64'(best_n) * 64'(REF_MAX_KHZ) >= 64'(fin_q))
                       && (64'(best_n) * 64'(REF_MIN_KHZ) <= 64'(fin_q)) && (best_n != '0));

   // R6
   fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (best_n == '0) && (best_m == '0) && (lane_mbps == '0));

   // R6
   lane_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (64'(lane_mbps) * 64'd1000 >= 64'(best_freq_khz))
                       && (64'(lane_mbps) * 64'd1000 < 64'(best_freq_khz) + 64'd1000));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy ##1 !done);
endmodule

// File: tb/pll_div_search_test.sv
`timescale 1ns/1ps
module pll_div_search_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [19:0] fin_khz = '0;
   logic [19:0] pclk_khz = '0;
   logic [5:0]  bpp = '0;
   logic [2:0]  lanes = 3'd1;
   logic        busy, done, found;
   logic [19:0] best_n;
   logic [9:0]  best_m;
   logic [31:0] best_freq_khz;
   logic [10:0] lane_mbps;

   int n_chk = 0;
   int n_fail = 0;
   bit reported = 0;

   always #2 clk = ~clk;

   pll_div_search uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fin_khz(fin_khz),
      .pclk_khz(pclk_khz), .bpp(bpp), .lanes(lanes), .busy(busy), .done(done),
      .found(found), .best_n(best_n), .best_m(best_m),
      .best_freq_khz(best_freq_khz), .lane_mbps(lane_mbps)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   task automatic model(input longint fin, input longint pclk, input longint b,
                        input longint ln, output bit fnd, output longint n_o,
                        output longint m_o, output longint f_o, output longint l_o);
      longint q, r, tgt, fout, nmin, nmax, best, m, f, e;
      fnd = 0; n_o = 0; m_o = 0; f_o = 0; l_o = 0;
      q    = b / ln;
      r    = ((pclk * q * 10) / 8) / 1000;
      tgt  = (pclk != 0 && r < 1500) ? r : 1000;
      fout = tgt * 1000;
      nmin = (fin + 39999) / 40000;
      if (nmin == 0) nmin = 1;
      nmax = fin / 5000;
      best = 64'hFFFF_FFFF;
      for (longint n = nmin; n <= nmax; n++) begin
         m = (fout * n) / fin;
         if (m < 6 || m > 512) continue;
         m = m + (m % 2);
         f = (m * fin) / n;
         if (f < 80000 || f > 1500000) continue;
         e = (fout > f) ? fout - f : f - fout;
         if (e < best) begin
            best = e; fnd = 1; n_o = n; m_o = m; f_o = f;
         end
      end
      if (fnd) l_o = (f_o + 999) / 1000;
   endtask

   task automatic run(input int fin, input int pclk, input int b, input int ln,
                      input bit inject);
      bit fnd; longint en, em, ef, el; bit got;
      model(fin, pclk, b, ln, fnd, en, em, ef, el);
      @(negedge clk);
      fin_khz = 20'(fin); pclk_khz = 20'(pclk); bpp = 6'(b); lanes = 3'(ln);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8 busy after start", busy, 1);
      if (inject) begin
         repeat (3) @(negedge clk);
         fin_khz = 20'd77777; pclk_khz = 20'd33333; bpp = 6'd16; lanes = 3'd2;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         fin_khz = '0; pclk_khz = '0;
      end
      got = 0;
      for (int c = 0; c < 60000 && !got; c++) begin
         @(negedge clk);
         got = done;
      end
      if (!got) begin
         chk("watchdog: done never seen", 0, 1);
         return;
      end
      chk("R8 busy low with done", busy, 0);
      chk(inject ? "R7 found despite start while busy" : "R6 found", found, fnd);
      chk("R1 best_n", best_n, en);
      chk("R3 best_m", best_m, em);
      chk("R4 best_freq_khz", best_freq_khz, ef);
      chk("R5 best_n strict-minimum choice", best_n, en);
      chk("R6 lane_mbps", lane_mbps, el);
      @(negedge clk);
      chk("R8 done is one pulse", done, 0);
      chk("R8 busy stays low", busy, 0);
      chk("R8 best_freq_khz held", best_freq_khz, ef);
      chk("R8 lane_mbps held", lane_mbps, el);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      chk("watchdog: run exceeded cycle limit", 0, 1);
      report();
      $finish;
   end

   initial begin
      int f, p, b, l;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 busy after reset", busy, 0);
      chk("R9 done after reset", done, 0);
      chk("R9 found after reset", found, 0);
      chk("R9 best_n after reset", best_n, 0);
      chk("R9 lane_mbps after reset", lane_mbps, 0);

      run(24000, 148500, 24, 4, 0);    // R2 typical rate
      run(0, 148500, 24, 4, 0);        // R1 zero reference, empty range
      run(4999, 148500, 24, 4, 0);     // R1 upper bound 0
      run(100000, 0, 24, 4, 0);        // R2 zero pixel clock -> default
      run(24000, 900000, 24, 1, 0);    // R2 rate at or above cap -> default
      run(24000, 148500, 3, 4, 0);     // R3 quotient 0 -> all M too small
      run(5000, 148500, 24, 4, 0);     // R1 single N
      run(1000000, 148500, 24, 4, 0);  // R1 wide N range, R5 update at last N
      run(24000, 148500, 24, 4, 1);    // R7 start while busy
      run(40000, 74250, 16, 2, 0);     // R4 low VCO region

      for (int k = 0; k < 30; k++) begin
         f = int'($urandom_range(120000, 0));
         p = int'($urandom_range(300000, 0));
         case ($urandom_range(2, 0))
            0: b = 16;
            1: b = 18;
            default: b = 24;
         endcase
         l = int'($urandom_range(4, 1));
         run(f, p, b, l, (k % 7) == 3);
      end
      report();
      $finish;
   end
endmodule